// File: doc/BRIEF.md
# Dual-Mode Ring/Twisted-Ring Up/Down Counter

This block is a small synchronous sequencer that keeps its whole state in one 3-bit register. A mode input picks how the register advances. In ring mode a single set bit circulates through the three positions. In twisted-ring mode the register walks a six-state sequence: the bit shifted out at one end is inverted and fed back in at the other end. A direction input picks which way the pattern moves. Both inputs are sampled live on every enabled edge.

Two independent next-state functions, one for each mode, compute their results in parallel. A per-bit multiplexer under the mode input then selects which result is loaded. Each function detects register values that are not part of its own cycle and sends them to a fixed entry state. As a result, switching modes mid-count, or any upset, cannot leave the counter outside a valid cycle for more than one enabled step.

Top module: `ring_twist_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `state_q` becomes 3'b001 if `johnson_sel` is 0 and 3'b000 if `johnson_sel` is 1.
- R2: With `rst` low and `cnt_en` low, `state_q` keeps its value across the clock edge.
- R3: Ring mode (`johnson_sel`=0), up (`count_down`=0): each enabled edge moves the set bit one place toward the MSB, so the sequence is 001, 010, 100, 001 (bit 0 is the LSB).
- R4: Ring mode, down (`count_down`=1): the set bit moves toward the LSB, so the sequence is 001, 100, 010, 001.
- R5: Twisted-ring mode (`johnson_sel`=1), up: the register shifts toward the MSB and the inverted MSB enters bit 0, so the sequence is 000, 001, 011, 111, 110, 100, 000.
- R6: Twisted-ring mode, down: the register shifts toward the LSB and the inverted LSB enters bit 2, so the sequence is 000, 100, 110, 111, 011, 001, 000.
- R7: In ring mode, an enabled edge loads 001 from any value that does not have exactly one bit set (000, 011, 101, 110, 111).
- R8: In twisted-ring mode, an enabled edge loads 000 from 010 or 101.
- R9: A change of `johnson_sel` triggers no special action. The next enabled edge applies the newly selected mode's step, or its recovery, to the current register value.
- R10: Reset takes priority over a low `cnt_en`.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; the loaded value depends on `johnson_sel` |
| cnt_en | input | 1 | Advance enable; when low the register holds |
| johnson_sel | input | 1 | 0 = ring sequencing, 1 = twisted-ring sequencing |
| count_down | input | 1 | 0 = step up (toward MSB), 1 = step down (toward LSB) |
| state_q | output | 3 | Current counter register value |

## Verification
The embedded properties check on every cycle that reset loads the right seed for the mode, that a disabled edge holds the value, that an enabled step always lands on a value that is legal in the selected mode, that the step moves in the expected direction, and that detected illegal values recover to the correct entry state. Only the bench's scenarios can show the exact order of the ring and twisted-ring cycles in both directions, and what happens when the mode is switched mid-count from each reachable state. The bench does this by driving directed walks and a long random stretch against a behavioural sequence-table model, with comparisons on every clock.

// File: rtl/ring_twist_pkg.sv
package ring_twist_pkg;
  typedef enum logic {
    SEQ_RING  = 1'b0,
    SEQ_TWIST = 1'b1
  } seq_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } seq_dir_e;
endpackage

// File: rtl/ring_step_logic.sv
module ring_step_logic #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             down,
  output logic [WIDTH-1:0] nxt,
  output logic             illegal
);
  localparam logic [WIDTH-1:0] ENTRY = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic int unsigned ones_in(input logic [WIDTH-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < WIDTH; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [WIDTH-1:0] rotate(input logic [WIDTH-1:0] v, input logic dn);
    return dn ? {v[0], v[WIDTH-1:1]} : {v[WIDTH-2:0], v[WIDTH-1]};
  endfunction

  assign illegal = (ones_in(cur) != 1);
  assign nxt     = illegal ? ENTRY : rotate(cur, down);

  always_comb begin
    assert (!(illegal == 1'b0) || ($countones(nxt) == 1)) else $error("AST_RING_KEEPS_ONEHOT"); // R3
  end
endmodule

// File: rtl/twist_step_logic.sv
module twist_step_logic #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             down,
  output logic [WIDTH-1:0] nxt,
  output logic             illegal
);
  localparam logic [WIDTH-1:0] ENTRY = '0;
  localparam int               EDGES = WIDTH - 1;

  logic [EDGES-1:0] edge_flag;
  logic [WIDTH-1:0] shifted;

  generate
    for (genvar g = 0; g < EDGES; g++) begin : g_edge
      assign edge_flag[g] = cur[g] ^ cur[g+1];
    end
  endgenerate

  function automatic logic [WIDTH-1:0] twist(input logic [WIDTH-1:0] v, input logic dn);
    return dn ? {~v[0], v[WIDTH-1:1]} : {v[WIDTH-2:0], ~v[WIDTH-1]};
  endfunction

  assign illegal = ($countones(edge_flag) > 1);
  assign shifted = twist(cur, down);
  assign nxt     = illegal ? ENTRY : shifted;
endmodule

// File: rtl/ring_twist_counter.sv
module ring_twist_counter #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             johnson_sel,
  input  logic             count_down,
  output logic [WIDTH-1:0] state_q
);
  import ring_twist_pkg::*;

  localparam logic [WIDTH-1:0] RING_SEED  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] TWIST_SEED = '0;

  seq_mode_e        mode;
  seq_dir_e         dir;
  logic [WIDTH-1:0] ring_nxt, twist_nxt, step_nxt, seed;
  logic             ring_illegal, twist_illegal;

  assign mode = seq_mode_e'(johnson_sel);
  assign dir  = seq_dir_e'(count_down);
  assign seed = (mode == SEQ_TWIST) ? TWIST_SEED : RING_SEED;

  ring_step_logic #(.WIDTH(WIDTH)) u_ring (
    .cur(state_q), .down(dir == DIR_DOWN), .nxt(ring_nxt), .illegal(ring_illegal)
  );

  twist_step_logic #(.WIDTH(WIDTH)) u_twist (
    .cur(state_q), .down(dir == DIR_DOWN), .nxt(twist_nxt), .illegal(twist_illegal)
  );

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_sel
      assign step_nxt[b] = (mode == SEQ_TWIST) ? twist_nxt[b] : ring_nxt[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         state_q <= seed;
    else if (cnt_en) state_q <= step_nxt;
  end

  AST_RESET_SEED: assert property (@(posedge clk)
    rst |=> state_q == ($past(johnson_sel) ? TWIST_SEED : RING_SEED)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cnt_en) |=> $stable(state_q)); // R2
  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !johnson_sel) |=> $countones(state_q) == 1); // R7
  AST_RING_UP_ROT: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !johnson_sel && !count_down && !ring_illegal)
      |=> state_q == {$past(state_q[WIDTH-2:0]), $past(state_q[WIDTH-1])}); // R3
  AST_RING_DN_ROT: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !johnson_sel && count_down && !ring_illegal)
      |=> state_q == {$past(state_q[0]), $past(state_q[WIDTH-1:1])}); // R4
  AST_RING_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !johnson_sel && ring_illegal) |=> state_q == RING_SEED); // R7
  AST_TWIST_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && johnson_sel && twist_illegal) |=> state_q == TWIST_SEED); // R8
  AST_TWIST_UP_FEED: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && johnson_sel && !count_down && !twist_illegal)
      |=> state_q[0] == !$past(state_q[WIDTH-1])); // R5
  AST_TWIST_DN_FEED: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && johnson_sel && count_down && !twist_illegal)
      |=> state_q[WIDTH-1] == !$past(state_q[0])); // R6
  AST_TWIST_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && johnson_sel) |=> !twist_illegal); // R9
endmodule

// File: tb/ring_twist_counter_test.sv
`timescale 1ns/1ps
module ring_twist_counter_test;
  localparam real HALF = 2.0;
  localparam int  WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1, cnt_en = 1'b0, johnson_sel = 1'b0, count_down = 1'b0;
  logic [2:0] state_q;

  int checks = 0, failures = 0;
  bit finished = 0;

  int ring_cycle[3]  = '{1, 2, 4};
  int twist_cycle[6] = '{0, 1, 3, 7, 6, 4};

  int model_state = 0;
  bit prev_mode = 0;

  always #(HALF) clk = ~clk;

  ring_twist_counter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .johnson_sel(johnson_sel),
    .count_down(count_down), .state_q(state_q)
  );

  function automatic int find_pos(input int v, input bit twist);
    if (twist) begin
      for (int i = 0; i < 6; i++) if (twist_cycle[i] == v) return i;
    end else begin
      for (int i = 0; i < 3; i++) if (ring_cycle[i] == v) return i;
    end
    return -1;
  endfunction

  function automatic int predict(input int cur, input bit r, input bit en, input bit md, input bit dn);
    int p;
    if (r) return md ? 0 : 1;
    if (!en) return cur;
    p = find_pos(cur, md);
    if (md) begin
      if (p < 0) return 0;
      return twist_cycle[dn ? (p + 5) % 6 : (p + 1) % 6];
    end
    if (p < 0) return 1;
    return ring_cycle[dn ? (p + 2) % 3 : (p + 1) % 3];
  endfunction

  function automatic string tag_for(input int cur, input bit r, input bit en, input bit md, input bit dn, input bit pm);
    if (r && !en) return "R10";
    if (r) return "R1";
    if (!en) return "R2";
    if (md != pm) return "R9";
    if (!md) begin
      if (find_pos(cur, 0) < 0) return "R7";
      return dn ? "R4" : "R3";
    end
    if (find_pos(cur, 1) < 0) return "R8";
    return dn ? "R6" : "R5";
  endfunction

  task automatic step(input bit r, input bit en, input bit md, input bit dn);
    int    exp_v;
    string tg;
    rst = r; cnt_en = en; johnson_sel = md; count_down = dn;
    exp_v = predict(model_state, r, en, md, dn);
    tg    = tag_for(model_state, r, en, md, dn, prev_mode);
    @(negedge clk);
    checks++;
    if (int'(state_q) != exp_v) begin
      failures++;
      $display("FAIL %s: state_q=%03b expected=%03b", tg, state_q, exp_v[2:0]);
    end
    model_state = exp_v;
    prev_mode   = md;
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0);                               // R10 reset while disabled, ring seed
    step(1, 1, 1, 0);                               // R1 twist seed
    step(1, 1, 0, 0);                               // R1 ring seed
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);   // R3 ring up
    step(0, 0, 0, 1); step(0, 0, 1, 1);             // R2 hold
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1);   // R4 ring down
    step(1, 1, 1, 0);
    for (int i = 0; i < 7; i++) step(0, 1, 1, 0);   // R5 twist up
    for (int i = 0; i < 7; i++) step(0, 1, 1, 1);   // R6 twist down
    step(1, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 1, 0); // reach 011
    step(0, 1, 0, 0);                               // R9 011 in ring -> 001
    step(0, 1, 0, 0);                               // ring at 010
    step(0, 0, 1, 0);                               // hold while mode flips
    step(0, 1, 1, 0);                               // R8 010 in twist -> 000
    step(0, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 1, 0); // reach 111
    step(0, 0, 0, 0);                               // hold, mode to ring
    step(0, 1, 0, 0);                               // R7 111 in ring -> 001
    step(0, 1, 0, 0); step(0, 1, 0, 0);             // ring at 100
    step(0, 1, 1, 1);                               // R9 100 stepped by twist down
    for (int i = 0; i < 400; i++)
      step(($urandom % 40) == 0, ($urandom % 5) != 0, ($urandom % 6) == 0 ? ~johnson_sel : johnson_sel, $urandom % 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule